// File: doc/BRIEF.md
# Chip-Level Interrupt Collector

This block gathers the interrupt lines of a chip into one place for the host CPU. Four GPIO bank summary lines and six peripheral lines are shown together in a 10-bit pending-status word. Software reads that word until it is zero. A control register holds one enable bit per peripheral source and a single global enable. The block drives one registered interrupt request to the CPU.

The bank lines cannot be masked or cleared here. Each bank clears its own line. A peripheral line raises the CPU request only while its enable bit is set. The status word always shows the live input lines, masked or not, so repeated reads during one service pass see current state.

An edge-sensitive host can miss a request that stays high across a sleep period. Clearing the global enable and then setting it again pulls the request low for at least one cycle. If an enabled source is still pending, the request then rises again as a new edge.

Top module: `irq_collector`

## Requirements
- R1: Reading address 0 returns the pending-status word in `bus_rdata` one clock after the address is presented. Bits 3:0 are the live GPIO bank lines, with bank A in bit 0 up to bank D in bit 3.
- R2: In the status word, bits 9:4 are the live peripheral lines regardless of their enables. The order, from bit 4 upward, is LED channel 0, LED channel 1, LED channel 2, SPI, SMBus and one-wire. Bits 15:10 read as zero.
- R3: Address 1 is the control register. Bits 5:0 enable the peripheral sources in the same order as status bits 9:4. Bit 8 is the global enable. A read returns the written values in those bits and zero in all other bits.
- R4: After reset, the control register reads zero, `cpu_irq` is low and `bus_rdata` is zero.
- R5: `cpu_irq` is a register. It is high one clock after the global enable is set while any bank line is high, whatever the peripheral enables are.
- R6: A pending peripheral line whose enable bit is clear does not raise `cpu_irq`. The same line with its enable bit set does raise `cpu_irq`, one clock later.
- R7: While the global enable is clear, `cpu_irq` is low from the next clock on. If the enable is cleared by one write and set again by the next write, `cpu_irq` is low for at least one cycle. It then rises again, a new edge, if an enabled source is still pending.
- R8: Writes to address 0 or to any unmapped address have no effect on the control register. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_irq | input | 4 | GPIO bank summary interrupt lines, bank A in bit 0 |
| periph_irq | input | 6 | Peripheral interrupt lines: LED0, LED1, LED2, SPI, SMBus, one-wire |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| cpu_irq | output | 1 | Registered interrupt request to the host |

## Verification
The assertions assume three things about the inputs:
- The interrupt lines and bus signals are synchronous to `clk`.
- A write holds its address and data for the one cycle in which `bus_we` is high.
- The inputs carry no unknown values once reset is released.

The bench changes every input only at the falling clock edge, from tasks that hold the bus steady for a whole cycle. It samples results at the next falling edge, so each check sees exactly one register stage past its stimulus. It also counts rising edges of `cpu_irq`, so that the re-enable case is checked as a real new edge and not just as a level.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int N_BANK    = 4,
  parameter int N_PERIPH  = 6,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0,
  parameter int CTRL_ADDR = 1,
  parameter int GEN_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BANK-1:0]   bank_irq,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cpu_irq
);
  localparam int SRC_W = N_BANK + N_PERIPH;

  logic [N_PERIPH-1:0] src_en;
  logic                gen_en;
  logic [SRC_W-1:0]    status;
  logic                pend;
  logic [DATA_W-1:0]   ctrl_view;

  assign status = {periph_irq, bank_irq};
  assign pend   = (|bank_irq) | (|(periph_irq & src_en));

  always_comb begin
    ctrl_view = '0;
    ctrl_view[N_PERIPH-1:0] = src_en;
    ctrl_view[GEN_BIT] = gen_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_en <= '0;
      gen_en <= 1'b0;
    end else if (bus_we && bus_addr == ADDR_W'(CTRL_ADDR)) begin
      src_en <= bus_wdata[N_PERIPH-1:0];
      gen_en <= bus_wdata[GEN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      cpu_irq   <= 1'b0;
    end else begin
      cpu_irq <= gen_en & pend;
      if (bus_addr == ADDR_W'(STAT_ADDR))
        bus_rdata <= DATA_W'(status);
      else if (bus_addr == ADDR_W'(CTRL_ADDR))
        bus_rdata <= ctrl_view;
      else
        bus_rdata <= '0;
    end
  end

  assert_status_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(STAT_ADDR)) |=> (bus_rdata == DATA_W'($past({periph_irq, bank_irq}))));

  assert_bank_unmaskable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && |bank_irq) |=> cpu_irq);

  assert_periph_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_irq == '0 && (periph_irq & src_en) == '0) |=> !cpu_irq);

  assert_global_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !cpu_irq);

  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == ADDR_W'(CTRL_ADDR)) |=> ($stable(src_en) && $stable(gen_en)));
endmodule

// File: tb/sim_irq_collector.sv
module sim_irq_collector;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bank_irq = '0;
  logic [5:0]  periph_irq = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        cpu_irq;
  int checks = 0, fails = 0, edges = 0;
  logic done = 0;

  irq_collector u0 (.clk(clk), .rst_n(rst_n), .bank_irq(bank_irq), .periph_irq(periph_irq),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq));

  always #5 clk = ~clk;
  always @(posedge cpu_irq) edges++;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R4 rdata", bus_rdata, 16'h0);
    chk("R4 irq", {15'b0, cpu_irq}, 16'h0);
    rd(4'd1, d); chk("R4 ctrl", d, 16'h0);
  endtask

  task automatic t_status;
    logic [15:0] d;
    @(negedge clk); bank_irq = 4'b0101; periph_irq = 6'b000000;
    rd(4'd0, d); chk("R1 banks A,C", d, 16'h0005);
    @(negedge clk); bank_irq = 4'b1000; periph_irq = 6'b100001;
    rd(4'd0, d); chk("R2 LED0+onewire", d, 16'h0218);
    @(negedge clk); bank_irq = 4'b0000; periph_irq = 6'b001000;
    rd(4'd0, d); chk("R2 SPI bit7", d, 16'h0080);
    @(negedge clk); periph_irq = 6'b0;
    rd(4'd0, d); chk("R1 nothing pending", d, 16'h0000);
  endtask

  task automatic t_ctrl;
    logic [15:0] d;
    wr(4'd1, 16'hFFFF);
    rd(4'd1, d); chk("R3 readback ones", d, 16'h013F);
    wr(4'd1, 16'h0015);
    rd(4'd1, d); chk("R3 readback pattern", d, 16'h0015);
    wr(4'd0, 16'hFFFF);
    rd(4'd1, d); chk("R8 status write ignored", d, 16'h0015);
    wr(4'd7, 16'h0000);
    rd(4'd1, d); chk("R8 unmapped write ignored", d, 16'h0015);
    rd(4'd7, d); chk("R8 unmapped reads zero", d, 16'h0000);
    wr(4'd1, 16'h0000);
  endtask

  task automatic t_bank;
    wr(4'd1, 16'h0100);
    @(negedge clk); bank_irq = 4'b0010;
    chk("R5 not yet", {15'b0, cpu_irq}, 16'h0);
    @(negedge clk); chk("R5 bank B raises", {15'b0, cpu_irq}, 16'h1);
    bank_irq = 4'b0;
    @(negedge clk); chk("R5 bank drop", {15'b0, cpu_irq}, 16'h0);
  endtask

  task automatic t_periph;
    @(negedge clk); periph_irq = 6'b010000;
    @(negedge clk); chk("R6 SMBus disabled", {15'b0, cpu_irq}, 16'h0);
    wr(4'd1, 16'h0110);
    @(negedge clk); chk("R6 SMBus enabled", {15'b0, cpu_irq}, 16'h1);
    wr(4'd1, 16'h010F);
    @(negedge clk); chk("R6 other enables only", {15'b0, cpu_irq}, 16'h0);
    @(negedge clk); periph_irq = 6'b0;
  endtask

  task automatic t_toggle;
    int e0;
    wr(4'd1, 16'h0101);
    @(negedge clk); periph_irq = 6'b000001;
    @(negedge clk); chk("R7 pending high", {15'b0, cpu_irq}, 16'h1);
    e0 = edges;
    wr(4'd1, 16'h0001);
    wr(4'd1, 16'h0101);
    chk("R7 low gap", {15'b0, cpu_irq}, 16'h0);
    @(negedge clk); chk("R7 re-asserted", {15'b0, cpu_irq}, 16'h1);
    chk("R7 new edge", 16'(edges - e0), 16'h1);
    wr(4'd1, 16'h0001);
    @(negedge clk); chk("R7 global off", {15'b0, cpu_irq}, 16'h0);
    periph_irq = 6'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_status; t_ctrl; t_bank; t_periph; t_toggle;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule